// File: doc/BRIEF.md
# Accumulator ALU with Decimal Arithmetic

This block is the arithmetic and logic unit of an 8-bit accumulator processor. Each clock it takes an accumulator operand, a memory operand, the current processor status byte and a 4-bit operation select. One clock later it presents the 8-bit result and an updated status byte. Every operation has its own mask of the negative, overflow, zero and carry flags it may change. Any flag outside that mask, and every other status bit, is copied from the incoming status byte.

Add and subtract work in binary or packed BCD. The choice comes from the decimal flag (status bit 3) that arrives with the operands. The unit also covers the three bitwise logic operations, shifts and rotates through carry, compare, bit test, and increment and decrement of the accumulator. Decode of the operation select is kept apart from the arithmetic. It yields a small set of strobes that pick the function and the flag update mask.

Top module: `acc_alu8`

## Requirements
- R1: While reset (`rstN` low) is asserted, `result` and `statusOut` are both 0x00.
- R2: Status layout: bit7 N, bit6 V, bit3 D (decimal), bit1 Z, bit0 C. `result` and `statusOut` reflect the inputs sampled at the previous rising clock edge. Operation select codes: 0 add, 1 subtract, 2 OR, 3 AND, 4 XOR, 5 shift left, 6 shift right, 7 rotate left, 8 rotate right, 9 compare, 10 bit test, 11 increment, 12 decrement, 13 to 15 pass.
- R3: Add (code 0) with D=0 gives A+M+C modulo 256. C is the carry out of bit 7. V is set when A and M have the same sign and the result's sign differs. N and Z follow the result.
- R4: Subtract (code 1) with D=0 gives A−M−(1−C) modulo 256. C is 1 when no borrow occurs. V is set when A and M differ in sign and the result's sign differs from A's. N and Z follow the result.
- R5: Add with D=1 adds the low nibbles plus C, and adds 6 when that sum exceeds 9. It then adds the high nibbles plus a carry taken when the corrected low sum exceeds 15. C is set when the high sum exceeds 15. N, V and Z are left unchanged.
- R6: Subtract with D=1 subtracts the low nibbles and the borrow (1−C), and corrects by −6 when the low difference borrows. The high nibbles are subtracted with that borrow, with the same −6 correction. C is 0 exactly when the high nibble borrows. N, V and Z are left unchanged.
- R7: OR, AND and XOR (codes 2, 3, 4) combine A with M. They update only N and Z.
- R8: Shift left (code 5) moves A bit 7 into C and shifts 0 into bit 0. Shift right (code 6) moves A bit 0 into C and shifts 0 into bit 7. Both update N and Z.
- R9: Rotate left (code 7) puts the incoming C into bit 0 and A bit 7 into C. Rotate right (code 8) puts the incoming C into bit 7 and A bit 0 into C. Both update N and Z.
- R10: Compare (code 9) forms A−M without keeping it. The result output equals A. C is set when A ≥ M unsigned, N and Z come from the 8-bit difference, and V is left unchanged.
- R11: Bit test (code 10) copies M bit 7 to N and M bit 6 to V. Z is set when A AND M is zero. The result output equals A and C is left unchanged.
- R12: Increment (code 11) and decrement (code 12) of A wrap modulo 256. They update only N and Z.
- R13: Codes 13 to 15 output A and the status byte unchanged. For every operation, status bits 5 to 2 are copied from the status input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| opSel | input | 4 | Operation select code |
| opA | input | 8 | Accumulator operand |
| opM | input | 8 | Memory operand |
| statusIn | input | 8 | Current processor status byte |
| result | output | 8 | Registered 8-bit result |
| statusOut | output | 8 | Registered updated status byte |

## Verification
Both outputs are due one rising edge after the operands, select code and status are presented, with no extra pipeline stage for any operation. The bench applies each stimulus on a falling edge. It reads `result` and `statusOut` on the next falling edge, half a period after the capturing rising edge, so every sample falls in the cycle where the new value is held. Each case also drives flags that the operation must not touch to values opposite to the ones it writes. A broken mask therefore shows up in the same sample.

// File: rtl/acc_alu8_pkg.sv
package acc_alu8_pkg;

  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int OP_W   = 4;

  localparam int FLAG_N = 7;
  localparam int FLAG_V = 6;
  localparam int FLAG_D = 3;
  localparam int FLAG_Z = 1;
  localparam int FLAG_C = 0;

  localparam logic [OP_W-1:0] SEL_ADD = 4'd0;
  localparam logic [OP_W-1:0] SEL_SUB = 4'd1;
  localparam logic [OP_W-1:0] SEL_OR  = 4'd2;
  localparam logic [OP_W-1:0] SEL_AND = 4'd3;
  localparam logic [OP_W-1:0] SEL_XOR = 4'd4;
  localparam logic [OP_W-1:0] SEL_SHL = 4'd5;
  localparam logic [OP_W-1:0] SEL_SHR = 4'd6;
  localparam logic [OP_W-1:0] SEL_ROL = 4'd7;
  localparam logic [OP_W-1:0] SEL_ROR = 4'd8;
  localparam logic [OP_W-1:0] SEL_CMP = 4'd9;
  localparam logic [OP_W-1:0] SEL_BIT = 4'd10;
  localparam logic [OP_W-1:0] SEL_INC = 4'd11;
  localparam logic [OP_W-1:0] SEL_DEC = 4'd12;

  typedef enum logic [3:0] {
    FN_BINADD, FN_BINSUB, FN_BCDADD, FN_BCDSUB,
    FN_OR, FN_AND, FN_XOR,
    FN_SHL, FN_SHR, FN_ROL, FN_ROR,
    FN_CMP, FN_BIT, FN_INC, FN_DEC, FN_PASS
  } aluFn_e;

  typedef struct packed {
    aluFn_e fn;
    logic   updN;
    logic   updV;
    logic   updZ;
    logic   updC;
  } aluCtrl_t;

endpackage

// File: rtl/acc_alu8_ctrl.sv
module acc_alu8_ctrl
  import acc_alu8_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  input  logic            decimalMode,
  output aluCtrl_t        ctrl
);

  always_comb begin
    ctrl = '{fn: FN_PASS, updN: 1'b0, updV: 1'b0, updZ: 1'b0, updC: 1'b0};
    case (opSel)
      SEL_ADD: begin
        if (decimalMode) ctrl = '{fn: FN_BCDADD, updN: 1'b0, updV: 1'b0, updZ: 1'b0, updC: 1'b1};
        else             ctrl = '{fn: FN_BINADD, updN: 1'b1, updV: 1'b1, updZ: 1'b1, updC: 1'b1};
      end
      SEL_SUB: begin
        if (decimalMode) ctrl = '{fn: FN_BCDSUB, updN: 1'b0, updV: 1'b0, updZ: 1'b0, updC: 1'b1};
        else             ctrl = '{fn: FN_BINSUB, updN: 1'b1, updV: 1'b1, updZ: 1'b1, updC: 1'b1};
      end
      SEL_OR:  ctrl = '{fn: FN_OR,  updN: 1'b1, updV: 1'b0, updZ: 1'b1, updC: 1'b0};
      SEL_AND: ctrl = '{fn: FN_AND, updN: 1'b1, updV: 1'b0, updZ: 1'b1, updC: 1'b0};
      SEL_XOR: ctrl = '{fn: FN_XOR, updN: 1'b1, updV: 1'b0, updZ: 1'b1, updC: 1'b0};
      SEL_SHL: ctrl = '{fn: FN_SHL, updN: 1'b1, updV: 1'b0, updZ: 1'b1, updC: 1'b1};
      SEL_SHR: ctrl = '{fn: FN_SHR, updN: 1'b1, updV: 1'b0, updZ: 1'b1, updC: 1'b1};
      SEL_ROL: ctrl = '{fn: FN_ROL, updN: 1'b1, updV: 1'b0, updZ: 1'b1, updC: 1'b1};
      SEL_ROR: ctrl = '{fn: FN_ROR, updN: 1'b1, updV: 1'b0, updZ: 1'b1, updC: 1'b1};
      SEL_CMP: ctrl = '{fn: FN_CMP, updN: 1'b1, updV: 1'b0, updZ: 1'b1, updC: 1'b1};
      SEL_BIT: ctrl = '{fn: FN_BIT, updN: 1'b1, updV: 1'b1, updZ: 1'b1, updC: 1'b0};
      SEL_INC: ctrl = '{fn: FN_INC, updN: 1'b1, updV: 1'b0, updZ: 1'b1, updC: 1'b0};
      SEL_DEC: ctrl = '{fn: FN_DEC, updN: 1'b1, updV: 1'b0, updZ: 1'b1, updC: 1'b0};
      default: ctrl = '{fn: FN_PASS, updN: 1'b0, updV: 1'b0, updZ: 1'b0, updC: 1'b0};
    endcase
  end

endmodule

// File: rtl/acc_alu8_bcd.sv
module acc_alu8_bcd
  import acc_alu8_pkg::*;
(
  input  logic [DATA_W-1:0] bcdA,
  input  logic [DATA_W-1:0] bcdM,
  input  logic              carryIn,
  output logic [DATA_W-1:0] addRes,
  output logic              addCarry,
  output logic [DATA_W-1:0] subRes,
  output logic              subCarry
);

  logic [NIB_W+1:0] loSum, loSumFix, hiSum;
  logic [NIB_W:0]   loDiff, hiDiff;
  logic [NIB_W-1:0] loDiffFix, hiDiffFix;
  logic             loBorrow, hiBorrow;

  // add: low nibble corrected by +6 past nine, high nibble uncorrected
  always_comb begin
    loSum    = {2'b00, bcdA[NIB_W-1:0]} + {2'b00, bcdM[NIB_W-1:0]} + {{(NIB_W+1){1'b0}}, carryIn};
    loSumFix = (loSum > 6'd9) ? loSum + 6'd6 : loSum;
    hiSum    = {2'b00, bcdA[DATA_W-1:NIB_W]} + {2'b00, bcdM[DATA_W-1:NIB_W]}
             + {{(NIB_W+1){1'b0}}, (loSumFix > 6'd15)};
    addRes   = {hiSum[NIB_W-1:0], loSumFix[NIB_W-1:0]};
    addCarry = (hiSum > 6'd15);
  end

  // subtract: each nibble corrected by -6 when it borrows
  always_comb begin
    loDiff    = {1'b0, bcdA[NIB_W-1:0]} - {1'b0, bcdM[NIB_W-1:0]} - {{NIB_W{1'b0}}, ~carryIn};
    loBorrow  = loDiff[NIB_W];
    loDiffFix = loBorrow ? loDiff[NIB_W-1:0] - 4'd6 : loDiff[NIB_W-1:0];
    hiDiff    = {1'b0, bcdA[DATA_W-1:NIB_W]} - {1'b0, bcdM[DATA_W-1:NIB_W]} - {{NIB_W{1'b0}}, loBorrow};
    hiBorrow  = hiDiff[NIB_W];
    hiDiffFix = hiBorrow ? hiDiff[NIB_W-1:0] - 4'd6 : hiDiff[NIB_W-1:0];
    subRes    = {hiDiffFix, loDiffFix};
    subCarry  = ~hiBorrow;
  end

endmodule

// File: rtl/acc_alu8_datapath.sv
module acc_alu8_datapath
  import acc_alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opM,
  input  logic [DATA_W-1:0] statusIn,
  output logic [DATA_W-1:0] resultQ,
  output logic [DATA_W-1:0] statusQ
);

  logic              cIn;
  logic [DATA_W:0]   addSum, subDiff, cmpDiff;
  logic [DATA_W-1:0] bcdAddRes, bcdSubRes;
  logic              bcdAddC, bcdSubC;
  logic [DATA_W-1:0] resNext, statusNext;
  logic              nCand, vCand, zCand, cCand;

  assign cIn = statusIn[FLAG_C];

  acc_alu8_bcd bcd_i (
    .bcdA(opA), .bcdM(opM), .carryIn(cIn),
    .addRes(bcdAddRes), .addCarry(bcdAddC),
    .subRes(bcdSubRes), .subCarry(bcdSubC)
  );

  always_comb begin
    addSum  = {1'b0, opA} + {1'b0, opM} + {{DATA_W{1'b0}}, cIn};
    subDiff = {1'b0, opA} - {1'b0, opM} - {{DATA_W{1'b0}}, ~cIn};
    cmpDiff = {1'b0, opA} - {1'b0, opM};
    resNext = opA;
    vCand   = statusIn[FLAG_V];
    cCand   = statusIn[FLAG_C];
    case (ctrl.fn)
      FN_BINADD: begin
        resNext = addSum[DATA_W-1:0];
        cCand   = addSum[DATA_W];
        vCand   = (opA[DATA_W-1] == opM[DATA_W-1]) && (addSum[DATA_W-1] != opA[DATA_W-1]);
      end
      FN_BINSUB: begin
        resNext = subDiff[DATA_W-1:0];
        cCand   = ~subDiff[DATA_W];
        vCand   = (opA[DATA_W-1] != opM[DATA_W-1]) && (subDiff[DATA_W-1] != opA[DATA_W-1]);
      end
      FN_BCDADD: begin resNext = bcdAddRes; cCand = bcdAddC; end
      FN_BCDSUB: begin resNext = bcdSubRes; cCand = bcdSubC; end
      FN_OR:     resNext = opA | opM;
      FN_AND:    resNext = opA & opM;
      FN_XOR:    resNext = opA ^ opM;
      FN_SHL:    begin resNext = {opA[DATA_W-2:0], 1'b0}; cCand = opA[DATA_W-1]; end
      FN_SHR:    begin resNext = {1'b0, opA[DATA_W-1:1]}; cCand = opA[0]; end
      FN_ROL:    begin resNext = {opA[DATA_W-2:0], cIn};  cCand = opA[DATA_W-1]; end
      FN_ROR:    begin resNext = {cIn, opA[DATA_W-1:1]};  cCand = opA[0]; end
      FN_INC:    resNext = opA + 1'b1;
      FN_DEC:    resNext = opA - 1'b1;
      default:   resNext = opA;
    endcase
    nCand = resNext[DATA_W-1];
    zCand = (resNext == '0);
    if (ctrl.fn == FN_CMP) begin
      nCand = cmpDiff[DATA_W-1];
      zCand = (cmpDiff[DATA_W-1:0] == '0);
      cCand = ~cmpDiff[DATA_W];
    end else if (ctrl.fn == FN_BIT) begin
      nCand = opM[DATA_W-1];
      vCand = opM[DATA_W-2];
      zCand = ((opA & opM) == '0);
    end
  end

  always_comb begin
    statusNext = statusIn;
    if (ctrl.updN) statusNext[FLAG_N] = nCand;
    if (ctrl.updV) statusNext[FLAG_V] = vCand;
    if (ctrl.updZ) statusNext[FLAG_Z] = zCand;
    if (ctrl.updC) statusNext[FLAG_C] = cCand;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      statusQ <= '0;
    end else begin
      resultQ <= resNext;
      statusQ <= statusNext;
    end
  end

  AST_MID_BITS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> statusQ[5:2] == $past(statusIn[5:2])); // R13
  AST_BIT_COPIES_NV: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(ctrl.fn == FN_BIT)) |-> statusQ[7:6] == $past(opM[7:6])); // R11
  AST_TEST_KEEPS_A: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(ctrl.fn == FN_CMP || ctrl.fn == FN_BIT)) |-> resultQ == $past(opA)); // R10
  AST_INC_WRAPS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(ctrl.fn == FN_INC)) |-> resultQ == DATA_W'($past(opA) + 1'b1)); // R12
  AST_LOGIC_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(ctrl.fn == FN_AND || ctrl.fn == FN_OR || ctrl.fn == FN_XOR))
    |-> statusQ[FLAG_Z] == (resultQ == '0)); // R7
  AST_BCD_KEEPS_NVZ: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(ctrl.fn == FN_BCDADD || ctrl.fn == FN_BCDSUB))
    |-> (statusQ[7:6] == $past(statusIn[7:6]) && statusQ[FLAG_Z] == $past(statusIn[FLAG_Z]))); // R5

endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
  import acc_alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opM,
  input  logic [DATA_W-1:0] statusIn,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] statusOut
);

  aluCtrl_t ctrl;

  acc_alu8_ctrl ctrl_i (
    .opSel(opSel),
    .decimalMode(statusIn[FLAG_D]),
    .ctrl(ctrl)
  );

  acc_alu8_datapath dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .opA(opA), .opM(opM), .statusIn(statusIn),
    .resultQ(result), .statusQ(statusOut)
  );

endmodule

// File: tb/acc_alu8_tb_top.sv
`timescale 1ns/1ps
module acc_alu8_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] opSel = '0;
  logic [7:0] opA = '0, opM = '0, statusIn = '0;
  logic [7:0] result, statusOut;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  acc_alu8 dut_i (
    .clk(clk), .rstN(rstN), .opSel(opSel), .opA(opA), .opM(opM),
    .statusIn(statusIn), .result(result), .statusOut(statusOut)
  );

  task automatic checkOut(input string tag, input logic [7:0] expR, input logic [7:0] expS);
    checks++;
    if (result !== expR || statusOut !== expS) begin
      errors++;
      $display("FAIL %s: result=%02h status=%02h expected result=%02h status=%02h",
               tag, result, statusOut, expR, expS);
    end
  endtask

  // drive on a falling edge, sample on the next falling edge (one register stage)
  task automatic runOp(input string tag, input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] m, input logic [7:0] st,
                       input logic [7:0] expR, input logic [7:0] expS);
    @(negedge clk);
    opSel = op; opA = a; opM = m; statusIn = st;
    @(negedge clk);
    checkOut(tag, expR, expS);
  endtask

  task automatic testReset();
    @(negedge clk);
    opSel = 4'd0; opA = 8'hFF; opM = 8'h01; statusIn = 8'hFF;
    @(negedge clk);
    checkOut("R1 reset holds zero", 8'h00, 8'h00);
    rstN = 1'b1;
  endtask

  task automatic testBinAdd();
    runOp("R3 R2 add signed overflow", 4'd0, 8'h50, 8'h50, 8'h20, 8'hA0, 8'hE0);
    runOp("R3 add carry out zero",     4'd0, 8'hFF, 8'h01, 8'h20, 8'h00, 8'h23);
    runOp("R3 add carry in",           4'd0, 8'h01, 8'h01, 8'h21, 8'h03, 8'h20);
  endtask

  task automatic testBinSub();
    runOp("R4 sub borrow overflow", 4'd1, 8'h50, 8'hB0, 8'h21, 8'hA0, 8'hE0);
    runOp("R4 sub borrow in",       4'd1, 8'h05, 8'h03, 8'h20, 8'h01, 8'h21);
    runOp("R4 sub equal zero",      4'd1, 8'h03, 8'h03, 8'h21, 8'h00, 8'h23);
  endtask

  task automatic testBcdAdd();
    runOp("R5 bcd add low fix keep NVZ", 4'd0, 8'h45, 8'h38, 8'hEA, 8'h83, 8'hEA);
    runOp("R5 bcd add carry out",        4'd0, 8'h90, 8'h80, 8'h28, 8'h10, 8'h29);
    runOp("R5 bcd add carry in",         4'd0, 8'h19, 8'h01, 8'h29, 8'h21, 8'h28);
  endtask

  task automatic testBcdSub();
    runOp("R6 bcd sub low borrow", 4'd1, 8'h42, 8'h17, 8'h29, 8'h25, 8'h29);
    runOp("R6 bcd sub high borrow", 4'd1, 8'h10, 8'h20, 8'h29, 8'h90, 8'h28);
    runOp("R6 bcd sub borrow in",   4'd1, 8'h50, 8'h01, 8'hA8, 8'h48, 8'hA9);
  endtask

  task automatic testLogic();
    runOp("R7 or",  4'd2, 8'h0F, 8'hF0, 8'h61, 8'hFF, 8'hE1);
    runOp("R7 and", 4'd3, 8'h0F, 8'hF0, 8'h61, 8'h00, 8'h63);
    runOp("R7 xor", 4'd4, 8'h3C, 8'h0F, 8'hE3, 8'h33, 8'h61);
  endtask

  task automatic testShift();
    runOp("R8 shl carry out", 4'd5, 8'h81, 8'h00, 8'h20, 8'h02, 8'h21);
    runOp("R8 shl negative",  4'd5, 8'h40, 8'h00, 8'h21, 8'h80, 8'hA0);
    runOp("R8 shr to zero",   4'd6, 8'h01, 8'h00, 8'h20, 8'h00, 8'h23);
    runOp("R8 shr zero fill", 4'd6, 8'h80, 8'h00, 8'hA1, 8'h40, 8'h20);
  endtask

  task automatic testRotate();
    runOp("R9 rol carry through", 4'd7, 8'h80, 8'h00, 8'h21, 8'h01, 8'h21);
    runOp("R9 rol no carry",      4'd7, 8'h40, 8'h00, 8'h20, 8'h80, 8'hA0);
    runOp("R9 ror carry through", 4'd8, 8'h01, 8'h00, 8'h21, 8'h80, 8'hA1);
    runOp("R9 ror no carry",      4'd8, 8'h02, 8'h00, 8'h20, 8'h01, 8'h20);
  endtask

  task automatic testCompare();
    runOp("R10 cmp equal",   4'd9, 8'h10, 8'h10, 8'h60, 8'h10, 8'h63);
    runOp("R10 cmp less",    4'd9, 8'h10, 8'h20, 8'h23, 8'h10, 8'hA0);
    runOp("R10 cmp greater", 4'd9, 8'h20, 8'h10, 8'h20, 8'h20, 8'h21);
  endtask

  task automatic testBitTest();
    runOp("R11 bit sets NVZ",   4'd10, 8'h0F, 8'hC0, 8'h21, 8'h0F, 8'hE3);
    runOp("R11 bit clears NVZ", 4'd10, 8'hFF, 8'h01, 8'hE2, 8'hFF, 8'h20);
  endtask

  task automatic testIncDec();
    runOp("R12 inc wraps",    4'd11, 8'hFF, 8'h00, 8'h21, 8'h00, 8'h23);
    runOp("R12 inc negative", 4'd11, 8'h7F, 8'h00, 8'h62, 8'h80, 8'hE0);
    runOp("R12 dec wraps",    4'd12, 8'h00, 8'h00, 8'h21, 8'hFF, 8'hA1);
    runOp("R12 dec to zero",  4'd12, 8'h01, 8'h00, 8'h20, 8'h00, 8'h22);
  endtask

  task automatic testPass();
    runOp("R13 pass all ones", 4'd13, 8'h5A, 8'h33, 8'hFF, 8'h5A, 8'hFF);
    runOp("R13 pass zero",     4'd15, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00);
    runOp("R13 mid bits add",  4'd0,  8'h00, 8'h00, 8'h14, 8'h00, 8'h16);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testBinAdd();
    testBinSub();
    testBcdAdd();
    testBcdSub();
    testLogic();
    testShift();
    testRotate();
    testCompare();
    testBitTest();
    testIncDec();
    testPass();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule